// File: doc/BRIEF.md
# Descriptor Ring Queue Controller

This block keeps the indices of one descriptor ring that serves a single direction of a copy engine. The ring holds a power-of-two number of slots. Software stages descriptors in ring memory, then writes a count into a doorbell register. The controller adds that count to the hardware tail and emits a one-cycle launch pulse that carries the count to the fetch logic. The fetch logic reports each finished descriptor on a retire strobe. Descriptors finish strictly in ring order, so a head index tracks them.

Completion is acknowledged by software, not by any hardware completion queue. Software writes an acknowledged count to the completion register, and the completion index moves forward by that count. The controller reports how many slots are free, always holding back a guard gap of 16 slots. It also keeps a 2-bit phase that steps on every wrap of the tail. A doorbell that does not fit in the free space is rejected. An acknowledge that would overtake the tail is rejected. Either case sets a sticky error flag.

Top module: `desc_ring_ctl`

## Requirements
- R1: After reset the head, completion index, tail, phase and error flag all read zero, and the free count reads RING_SIZE-16 (240 with the defaults).
- R2: A write of n (1 ≤ n ≤ free) to offset 0x38 adds n to the tail modulo RING_SIZE. On the next cycle it raises `launch_valid` for exactly one cycle, with `launch_cnt` = n.
- R3: A doorbell write whose full 32-bit count exceeds the free count leaves the tail unchanged, produces no launch and sets the error flag. A doorbell count of 0 changes nothing and sets no error.
- R4: Status bits [15:0] (offset 0x3C) give the free count: RING_SIZE-16-((tail-completion) mod RING_SIZE), clamped at zero. The free count never lets occupancy exceed RING_SIZE-16.
- R5: A write of k to offset 0x34, where k ≤ (tail-completion) mod RING_SIZE, advances the completion index by k modulo RING_SIZE. Reading 0x34 returns the completion index.
- R6: An acknowledge count larger than the outstanding count (tail-completion) mod RING_SIZE is ignored and sets the error flag.
- R7: Status bits [25:24] give the ring phase. The phase becomes (phase+1) mod 4 on every accepted doorbell that carries the tail past slot RING_SIZE-1 back toward 0. It changes at no other time.
- R8: A one-cycle `retire` pulse advances the head (offset 0x30) by one when head ≠ tail. It is ignored when head = tail, so the head never moves by more than one per cycle.
- R9: The error flag (status bit 31) stays set until a write to 0x3C with bit 31 set clears it. Other writes leave it unchanged.
- R10: Reads of any offset other than 0x30, 0x34, 0x38 and 0x3C return zero. Writes to 0x30 or to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Write byte offset |
| reg_wdata | input | 32 | Write data (count or clear bit) |
| reg_raddr | input | 8 | Read byte offset |
| reg_rdata | output | 32 | Combinational read data |
| retire | input | 1 | Fetch logic reports one descriptor finished |
| launch_valid | output | 1 | One-cycle launch pulse |
| launch_cnt | output | 8 | Descriptors launched with the pulse |

## Verification
The hardest condition to reach is the phase returning to zero. That needs four complete trips around the ring, and every trip must keep the ring below the guard limit. The stimulus alternates an acknowledge of everything outstanding with a large doorbell, so each doorbell fits and the tail crosses the end of the ring again and again. The status register is read after every step. The boundary doorbells are set up by first filling the ring to exactly zero free slots and then pushing one more. These are a count equal to the free space and a count one above it.

// File: rtl/ring_q_pkg.sv
// Shared offsets and the decoded register command for the ring controller.
package ring_q_pkg;
    localparam logic [7:0] OFS_HEAD = 8'h30;
    localparam logic [7:0] OFS_COMP = 8'h34;
    localparam logic [7:0] OFS_TAIL = 8'h38;
    localparam logic [7:0] OFS_STAT = 8'h3C;
    localparam int         STAT_ERR_BIT = 31;

    typedef struct packed {
        logic        db;    // doorbell write
        logic        ack;   // completion acknowledge write
        logic        clr;   // error clear request
        logic [31:0] cnt;   // count carried by the write
    } reg_cmd_t;
endpackage

// File: rtl/ring_ptr.sv
// Ring index register: adds a count modulo 2**IDXW and flags a wrap.
// Assumes add_cnt is below the ring size, so at most one wrap per add.
module ring_ptr #(
    parameter int IDXW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            add_en,
    input  logic [IDXW-1:0] add_cnt,
    output logic [IDXW-1:0] idx,
    output logic            wrap
);
    logic [IDXW:0] sum;

    // Wide sum: the carry out marks a crossing of the last slot.
    always_comb begin
        sum  = {1'b0, idx} + {1'b0, add_cnt};
        wrap = add_en & sum[IDXW];
    end

    // Index register, masked to the ring size by truncation.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx <= '0;
        else if (add_en) idx <= sum[IDXW-1:0];
    end
endmodule

// File: rtl/ring_space.sv
// Occupancy and free-slot arithmetic. Free space withholds GUARD slots.
// Assumes GUARD < 2**IDXW. Pure combinational.
module ring_space #(
    parameter int IDXW  = 8,
    parameter int GUARD = 16
) (
    input  logic [IDXW-1:0] tail,
    input  logic [IDXW-1:0] comp,
    output logic [IDXW-1:0] used,
    output logic [IDXW:0]   avail
);
    localparam int CAP = (1 << IDXW) - GUARD;

    // Free count clamped at zero once occupancy reaches the cap.
    always_comb begin
        used = tail - comp;
        if ({1'b0, used} >= (IDXW+1)'(CAP)) avail = '0;
        else                                avail = (IDXW+1)'(CAP) - {1'b0, used};
    end
endmodule

// File: rtl/ring_regif.sv
// Register decode: turns the write port into commands and muxes reads.
// Assumes single-cycle writes and a combinational read path.
module ring_regif
    import ring_q_pkg::*;
#(
    parameter int IDXW = 8
) (
    input  logic            wr,
    input  logic [7:0]      waddr,
    input  logic [31:0]     wdata,
    input  logic [7:0]      raddr,
    input  logic [IDXW-1:0] head,
    input  logic [IDXW-1:0] comp,
    input  logic [IDXW-1:0] tail,
    input  logic [1:0]      phase,
    input  logic            err,
    input  logic [IDXW:0]   avail,
    output reg_cmd_t        cmd,
    output logic [31:0]     rdata
);
    // Write decode into the command bundle.
    always_comb begin
        cmd.db  = wr && (waddr == OFS_TAIL);
        cmd.ack = wr && (waddr == OFS_COMP);
        cmd.clr = wr && (waddr == OFS_STAT) && wdata[STAT_ERR_BIT];
        cmd.cnt = wdata;
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        case (raddr)
            OFS_HEAD: rdata = 32'(head);
            OFS_COMP: rdata = 32'(comp);
            OFS_TAIL: rdata = 32'(tail);
            OFS_STAT: rdata = {err, 5'b0, phase, 8'b0, 16'(avail)};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/desc_ring_ctl.sv
// Single-direction descriptor ring controller. It holds tail (doorbell
// adds), completion (software acknowledges), head (in-order retire) and a
// 2-bit wrap phase. Assumes RING_SIZE is a power of two above GUARD.
module desc_ring_ctl
    import ring_q_pkg::*;
#(
    parameter int RING_SIZE = 256,
    parameter int GUARD     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [7:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    input  logic        retire,
    output logic        launch_valid,
    output logic [$clog2(RING_SIZE)-1:0] launch_cnt
);
    localparam int IDXW = $clog2(RING_SIZE);
    localparam int CAP  = RING_SIZE - GUARD;

    reg_cmd_t        cmd;
    logic [IDXW-1:0] head, comp, tail, used;
    logic [IDXW:0]   avail;
    logic [1:0]      phase;
    logic            err;
    logic            tail_wrap, comp_wrap, head_wrap;
    logic            db_ok, db_bad, ack_ok, ack_bad, ret_ok;

    ring_regif #(.IDXW(IDXW)) u_regif (
        .wr(reg_wr), .waddr(reg_waddr), .wdata(reg_wdata), .raddr(reg_raddr),
        .head(head), .comp(comp), .tail(tail), .phase(phase), .err(err),
        .avail(avail), .cmd(cmd), .rdata(reg_rdata)
    );

    ring_space #(.IDXW(IDXW), .GUARD(GUARD)) u_space (
        .tail(tail), .comp(comp), .used(used), .avail(avail)
    );

    // Accept / reject decisions for doorbell, acknowledge and retire.
    always_comb begin
        db_ok   = cmd.db  && (cmd.cnt != 0) && (cmd.cnt <= 32'(avail));
        db_bad  = cmd.db  && (cmd.cnt > 32'(avail));
        ack_ok  = cmd.ack && (cmd.cnt <= 32'(used));
        ack_bad = cmd.ack && (cmd.cnt > 32'(used));
        ret_ok  = retire && (head != tail);
    end

    ring_ptr #(.IDXW(IDXW)) u_tail (
        .clk(clk), .rst_n(rst_n), .add_en(db_ok), .add_cnt(cmd.cnt[IDXW-1:0]),
        .idx(tail), .wrap(tail_wrap)
    );
    ring_ptr #(.IDXW(IDXW)) u_comp (
        .clk(clk), .rst_n(rst_n), .add_en(ack_ok), .add_cnt(cmd.cnt[IDXW-1:0]),
        .idx(comp), .wrap(comp_wrap)
    );
    ring_ptr #(.IDXW(IDXW)) u_head (
        .clk(clk), .rst_n(rst_n), .add_en(ret_ok), .add_cnt(IDXW'(1)),
        .idx(head), .wrap(head_wrap)
    );

    // Phase steps modulo 4 whenever the tail crosses the ring end.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase <= 2'd0;
        else if (tail_wrap) phase <= phase + 2'd1;
    end

    // Sticky error: a rejected doorbell or acknowledge sets it, clear resets it.
    always_ff @(posedge clk) begin
        if (!rst_n)                 err <= 1'b0;
        else if (db_bad || ack_bad) err <= 1'b1;
        else if (cmd.clr)           err <= 1'b0;
    end

    // One-cycle launch pulse carrying the accepted count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launch_valid <= 1'b0;
            launch_cnt   <= '0;
        end else begin
            launch_valid <= db_ok;
            launch_cnt   <= db_ok ? cmd.cnt[IDXW-1:0] : '0;
        end
    end

    // Occupancy never reaches into the guard gap (R4).
    p_guard_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        32'(IDXW'(tail - comp)) <= 32'(CAP));

    // A launch always carries a nonzero count within capacity (R2, R3).
    p_launch_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        launch_valid |-> (launch_cnt != 0) && (32'(launch_cnt) <= 32'(CAP)));

    // Head moves by at most one slot per cycle, in ring order (R8).
    p_head_in_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (head == $past(head)) || (head == IDXW'($past(head) + 1'b1)));

    // Retire at an empty launch window leaves head alone (R8).
    p_retire_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && head == tail) |=> $stable(head));

    // Phase only holds or steps by one (R7).
    p_phase_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase == $past(phase)) || (phase == 2'($past(phase) + 2'd1)));

    // Error stays set unless a clear write arrives (R9).
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !cmd.clr) |=> err);

    // Carry-outs of completion and head wraps are not needed downstream.
    logic unused_wraps;
    assign unused_wraps = comp_wrap ^ head_wrap;
endmodule

// File: tb/desc_ring_ctl_test.sv
// Scoreboard bench: doorbell driver queues expected launches, a monitor
// pops them; registers are compared against a model built from the brief.
module desc_ring_ctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int SIZE = 256;
    localparam int CAP  = 240;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [7:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        retire = 1'b0;
    logic        launch_valid;
    logic [7:0]  launch_cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int exp_q[$];
    int m_tail = 0, m_comp = 0, m_head = 0, m_phase = 0, m_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    desc_ring_ctl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .retire(retire), .launch_valid(launch_valid), .launch_cnt(launch_cnt)
    );

    function automatic int m_used();
        return (m_tail - m_comp) & (SIZE - 1);
    endfunction
    function automatic int m_avail();
        return (m_used() >= CAP) ? 0 : CAP - m_used();
    endfunction

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, string req, int exp);
        @(negedge clk);
        reg_raddr = a;
        #1;
        check(req, int'(reg_rdata), exp);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_waddr = 8'h00; reg_wdata = '0;
    endtask

    task automatic check_all(string req);
        rd(8'h30, {req, " head"}, m_head);
        rd(8'h34, {req, " comp"}, m_comp);
        rd(8'h38, {req, " tail"}, m_tail);
        rd(8'h3C, {req, " status"}, (m_err << 31) | (m_phase << 24) | m_avail());
    endtask

    // Driver: model the doorbell, queue the expected launch, then write.
    task automatic doorbell(int n);
        if (n != 0 && n <= m_avail()) begin
            exp_q.push_back(n);
            if (m_tail + n >= SIZE) m_phase = (m_phase + 1) & 3;
            m_tail = (m_tail + n) & (SIZE - 1);
        end else if (n > m_avail()) m_err = 1;
        wr(8'h38, n);
    endtask

    task automatic ack(int k);
        if (k <= m_used()) m_comp = (m_comp + k) & (SIZE - 1);
        else m_err = 1;
        wr(8'h34, k);
    endtask

    task automatic pulse_retire();
        if (m_head != m_tail) m_head = (m_head + 1) & (SIZE - 1);
        @(negedge clk); retire = 1'b1;
        @(negedge clk); retire = 1'b0;
    endtask

    // Monitor: every launch pulse must match the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && launch_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R2 unexpected launch actual=%0d expected=none", launch_cnt);
            end else begin
                check("R2 launch count", int'(launch_cnt), exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");
        check("R1 launch idle", int'(launch_valid), 0);

        doorbell(10);
        check_all("R2 doorbell");
        pulse_retire(); pulse_retire(); pulse_retire();
        check_all("R8 retire");
        ack(4);
        check_all("R5 ack");
        ack(7);
        check_all("R6 ack overrun");
        wr(8'h38 + 8'h08, 0); // unmapped offset 0x40 write: no effect
        wr(8'h30, 32'h5);     // head offset write: no effect
        check_all("R10 ignored writes");
        rd(8'h40, "R10 unmapped read", 0);
        rd(8'h00, "R10 unmapped read low", 0);
        wr(8'h3C, 32'h0000_00FF);  // bit 31 clear: flag stays
        check_all("R9 no clear");
        m_err = 0;
        wr(8'h3C, 32'h8000_0000);
        check_all("R9 clear");

        doorbell(m_avail() + 1);
        check_all("R3 oversize");
        m_err = 0; wr(8'h3C, 32'h8000_0000);
        doorbell(32'h0001_0005 & 32'h7FFF_FFFF); // huge count, rejected
        check_all("R3 huge count");
        m_err = 0; wr(8'h3C, 32'h8000_0000);
        doorbell(0);
        check_all("R3 zero count");
        doorbell(m_avail());
        check_all("R4 full ring");
        doorbell(1);
        check_all("R4 no space");
        m_err = 0; wr(8'h3C, 32'h8000_0000);

        ack(m_used());
        check_all("R5 ack all");
        doorbell(20);
        check_all("R7 first wrap");
        for (int i = 0; i < 8; i++) begin
            ack(m_used());
            doorbell(130);
            check_all("R7 wrap loop");
        end
        for (int i = 0; i < 4; i++) pulse_retire();
        check_all("R8 retire after wraps");

        // Drain head up to tail, then one more retire must be ignored.
        while (m_head != m_tail) begin
            @(negedge clk); retire = 1'b1;
            m_head = (m_head + 1) & (SIZE - 1);
        end
        @(negedge clk); retire = 1'b0;
        check_all("R8 head caught up");
        pulse_retire();
        check_all("R8 idle retire");

        repeat (3) @(negedge clk);
        check("R2 queue drained", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule